// File: doc/BRIEF.md
# Collision activity detector

This block sits behind the receiver of a collision pair and turns a roughly 10 MHz square wave, present only while two stations transmit at once, into a steady active-high collision flag for the media access controller. It samples the single-bit collision input with an oversampling clock (80 MHz nominal, eight samples per 10 MHz period). It passes the input through a synchronizer and a run-length filter, and keeps the flag raised as long as qualified level changes keep arriving.

A level change counts only when the new level has held for `MIN_PULSE` consecutive samples. Short spikes are dropped. Each qualified change reloads a hold-off counter of `HOLD` samples. The flag rises on a qualified change that arrives while the counter is still running, so two changes close together are needed. A static level therefore never raises it. The flag falls when the counter runs out. The flag is the output of a register.

Top module: `col_activity_det`

## Requirements
- R1: Reset clears the flag and the hold-off counter at once. After reset releases with the input low, a single input change does not raise the flag.
- R2: When a qualified change follows an earlier one within `HOLD` samples, the flag rises exactly 5 sample clocks after that second input change: two synchronizer stages plus three filter samples. At 80 MHz this is 62.5 ns from the change as seen at the first register, and within 60 ns of the third qualifying sample.
- R3: After the last input change of a burst, the flag stays high for 28 more sample clocks and is low at the 29th. That is `HOLD` = 24 samples after the last qualified change, or 362.5 ns at 80 MHz measured from the raw input.
- R4: A level that lasts fewer than `MIN_PULSE` (3) samples is noise. A square wave with 2-sample halves never raises the flag.
- R5: An input that changes once and then stays at a constant level never raises the flag.
- R6: Qualified changes spaced 25 samples apart (more than `HOLD`) never raise the flag. Changes spaced exactly 24 samples apart keep it raised.
- R7: While changes keep arriving with spacing between 3 and 24 samples, the flag stays high without a gap.
- R8: Levels held exactly 3 samples are qualified and raise the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_in | input | 1 | Raw collision activity input, asynchronous to clk |
| col_flag | output | 1 | Registered active-high collision flag |

## Verification
A wrong run counter shows up as a flag edge that arrives one or more samples early or late. Every rise and fall is checked on its exact sample, so such a shift is caught within the first burst. A hold-off counter that is loaded with the wrong value or decrements wrongly moves the fall away from the 29th sample after the last change. It can also break the 24-sample spacing boundary, which then either drops the flag or raises it where it should stay low. A stale arming state would raise the flag on an isolated change after reset or after a static level. Those cases are watched for tens of samples.

// File: rtl/col_activity_det.sv
module col_activity_det #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 3,
  parameter int HOLD        = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_in,
  output logic col_flag
);
  localparam int RUN_W  = $clog2(MIN_PULSE + 1);
  localparam int HOLD_W = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sampled;
  logic [RUN_W-1:0]       run_q;
  logic                   flt_q;
  logic [HOLD_W-1:0]      hold_q;
  logic                   differs;
  logic                   qual_edge;
  logic                   armed;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= col_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], col_in};
    end
  endgenerate

  assign sampled   = sync_q[SYNC_STAGES-1];
  assign differs   = sampled != flt_q;
  assign qual_edge = differs && (run_q == RUN_W'(MIN_PULSE - 1));
  assign armed     = hold_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flt_q <= 1'b0;
    end else if (qual_edge) begin
      run_q <= '0;
      flt_q <= sampled;
    end else if (differs) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      col_flag <= 1'b0;
    end else if (qual_edge) begin
      hold_q <= HOLD_W'(HOLD);
      if (armed) col_flag <= 1'b1;
    end else if (armed) begin
      hold_q <= hold_q - 1'b1;
      if (hold_q == HOLD_W'(1)) col_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/col_activity_chk.sv
module col_activity_chk #(
  parameter int MIN_PULSE = 3,
  parameter int HOLD      = 24,
  parameter int HOLD_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sampled,
  input logic              flt,
  input logic [HOLD_W-1:0] hold_cnt,
  input logic              col_flag
);
  always @(posedge clk)
    if (!rst_n) AST_RST_CLEAR: assert (!col_flag && hold_cnt == '0); // R1

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= HOLD_W'(HOLD)); // R3

  AST_FLAG_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_flag |-> hold_cnt != '0); // R3

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_flag) |-> (flt != $past(flt)) && ($past(hold_cnt) != '0)); // R2

  AST_FALL_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_flag) |-> (hold_cnt == '0) && ($past(hold_cnt) == HOLD_W'(1))); // R3

  generate
    if (MIN_PULSE >= 3) begin : g_run
      AST_QUAL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (flt != $past(flt)) |-> ($past(sampled) == flt) && ($past(sampled, 2) == flt)); // R4
    end
  endgenerate
endmodule

bind col_activity_det col_activity_chk #(
  .MIN_PULSE(MIN_PULSE), .HOLD(HOLD), .HOLD_W(HOLD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sampled(sampled), .flt(flt_q),
  .hold_cnt(hold_q), .col_flag(col_flag)
);

// File: tb/sim_col_activity_det.sv
module sim_col_activity_det;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic col_in = 1'b0;
  logic col_flag;
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;

  typedef struct {
    int    at;
    bit    val;
    string req;
  } exp_t;
  exp_t sb[$];

  col_activity_det u0 (.clk(clk), .rst_n(rst_n), .col_in(col_in), .col_flag(col_flag));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, bit act, bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: col_flag=%0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int at, bit val, string req);
    exp_t e;
    e.at = at; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.at < cyc) begin
        n_run++; n_fail++;
        $display("FAIL %s: sample for cycle %0d missed (actual none, expected %0b)", e.req, e.at, e.val);
      end else check(e.req, col_flag, e.val);
    end
  end

  // n input changes spaced h samples apart, expectations derived from R2..R8
  task automatic burst(int n, int h, string tag);
    int c0, cl;
    @(negedge clk);
    c0 = cyc;
    cl = c0 + (n - 1) * h;
    if (h < 3) begin
      for (int i = 0; i < n; i++) expect_at(c0 + i * h + 5, 1'b0, "R4");
    end else if (h > HOLD) begin
      for (int i = 0; i < n; i++) expect_at(c0 + i * h + 6, 1'b0, "R6");
    end else begin
      expect_at(c0 + h + 4, 1'b0, "R2");
      expect_at(c0 + h + 5, 1'b1, tag);
      for (int i = 2; i < n; i++) expect_at(c0 + i * h + 5, 1'b1, "R7");
      expect_at(cl + 28, 1'b1, "R3");
      expect_at(cl + 29, 1'b0, "R3");
    end
    for (int i = 0; i < n; i++) begin
      col_in = ~col_in;
      repeat (h) @(negedge clk);
    end
    repeat (36) @(negedge clk);
  endtask

  initial begin
    #80000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", col_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    burst(10, 4, "R2");    // nominal 10 MHz
    burst(6, 8, "R2");     // slower toggling
    burst(4, 3, "R8");     // shortest qualified level
    burst(5, 24, "R6");    // spacing equal to the hold window sustains
    burst(4, 25, "R6");    // spacing just beyond the window
    burst(20, 2, "R4");    // sub-threshold noise
    burst(4, 1, "R4");

    begin : steady
      int c0;
      @(negedge clk);
      c0 = cyc;
      expect_at(c0 + 5, 1'b0, "R5");
      expect_at(c0 + 20, 1'b0, "R5");
      expect_at(c0 + 60, 1'b0, "R5");
      col_in = ~col_in;
      repeat (70) @(negedge clk);
    end

    begin : reset_mid
      int c0;
      for (int i = 0; i < 8; i++) begin
        col_in = ~col_in;
        repeat (4) @(negedge clk);
      end
      check("R7", col_flag, 1'b1);
      rst_n = 1'b0;
      #1 check("R1", col_flag, 1'b0);
      col_in = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", col_flag, 1'b0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      c0 = cyc;
      expect_at(c0 + 5, 1'b0, "R1");
      expect_at(c0 + 12, 1'b0, "R1");
      expect_at(c0 + 30, 1'b0, "R1");
      col_in = 1'b1;
      repeat (40) @(negedge clk);
    end

    burst(12, 4, "R2");    // clean operation after reset
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule